// File: doc/BRIEF.md
# Ping-Pong SRAM Burst Address Sequencer

This block sits behind the SPI slave front end. The front end has already decoded a memory command, so each command reaches this block with a burst mode, a direction and a 20-bit start address. The block turns that command into byte addresses, a bank select and one-cycle read or write strobes for two SRAM banks. Together the two banks hold 2048 pages of 512 bytes.

After each byte the SPI side completes, the block moves its internal pointer on. The mode sets the rule: a single byte, a burst that stays inside one 512-byte page, or a linear burst that runs through the whole bank. A burst ends at once when the SPI select line goes high.

Read data comes back from the selected bank one cycle after the read strobe, ready for loading into the SPI output shifter. The bank is chosen once, when the command arrives. It stays fixed for the whole burst, and pointer increments never move it to the other bank.

Top module: `sram_burst_seq`

## Requirements
- R1: The command address is 20 bits wide. Bit 19 picks the bank (0 is the ping bank, 1 is the pong bank), bits 18:9 give the page within that bank and bits 8:0 give the byte within the page. `mem_addr` carries bits 18:0 and `mem_bank` carries bit 19.
- R2: In byte mode (`cmd_mode` 0) exactly one byte is transferred per command. Every later `byte_stb` in that burst produces no strobe.
- R3: In page mode (`cmd_mode` 1) the byte offset goes up by one after each byte. After offset 511 it returns to offset 0 of the same page.
- R4: In sequential mode (`cmd_mode` 2) the address goes up linearly across page boundaries. After 0x7FFFF it returns to 0x00000 in the same bank.
- R5: `mem_bank` keeps the value taken from the command for the whole burst.
- R6: In a write burst (`cmd_write` 1), each accepted `byte_stb` gives one cycle of `mem_we` in the following cycle, with `byte_wdata` on `mem_wdata`. `mem_we` and `mem_re` are never high together.
- R7: A read burst (`cmd_write` 0) raises `mem_re` at the start address in the cycle after `cmd_valid`. In page and sequential modes, each `byte_stb` raises `mem_re` at the next address in the cycle after it.
- R8: `rd_valid` is high in the cycle after `mem_re`. In that cycle `rd_data` carries the data of the bank that the read was issued to.
- R9: While `sel_n` is high the burst ends. A `byte_stb` or `cmd_valid` seen in such a cycle is ignored, and no later `byte_stb` causes a strobe until a new command arrives.
- R10: During reset `mem_we`, `mem_re` and `rd_valid` are low.
- R11: A command with `cmd_mode` 3 starts no burst and produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | SPI select, active low |
| cmd_valid | input | 1 | Decoded command present (one cycle) |
| cmd_mode | input | 2 | Burst mode: 0 byte, 1 page, 2 sequential, 3 reserved |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | 20 | Start address: bank, page, offset |
| byte_stb | input | 1 | One SPI byte completed |
| byte_wdata | input | 8 | Received byte for writes |
| ping_rdata | input | 8 | Read data from the ping bank |
| pong_rdata | input | 8 | Read data from the pong bank |
| mem_bank | output | 1 | Bank select for the current access |
| mem_addr | output | 19 | Byte address inside the bank |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data toward the SPI output shifter |

## Verification
Page bursts start at offset 510 or 511, which shows whether the pointer wraps inside its page or runs on into the next page. Sequential bursts start just below a page edge and at the top of the pong bank, which shows whether the pointer carries linearly and whether the top bit stays out of the increment. Byte-mode bursts with extra strobes, select dropping in the same cycle as a strobe, and reserved-mode commands check that nothing is written or read when it must not be. The read data model returns a pattern computed from bank and address, so a bank mix-up or a one-cycle slip in the data path shows up as a wrong value.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [1:0] {
    MODE_BYTE = 2'd0,
    MODE_PAGE = 2'd1,
    MODE_SEQ  = 2'd2,
    MODE_RSVD = 2'd3
  } burst_mode_e;
endpackage

// File: rtl/sram_seq_adv.sv
// Address advance rule: page mode wraps the offset field, sequential mode
// carries across pages and wraps at the bank top, byte mode holds.
module sram_seq_adv
  import sram_seq_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 10,
  localparam int LA_W  = OFF_W + PAGE_W
) (
  input  burst_mode_e      mode,
  input  logic [LA_W-1:0]  addr_i,
  output logic [LA_W-1:0]  addr_o
);
  logic [OFF_W-1:0] off_inc;

  assign off_inc = addr_i[OFF_W-1:0] + 1'b1;

  always_comb begin
    unique case (mode)
      MODE_PAGE: addr_o = {addr_i[LA_W-1:OFF_W], off_inc};
      MODE_SEQ:  addr_o = addr_i + 1'b1;
      default:   addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
// Burst state, pointer and strobe generation.
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 8,
  localparam int LA_W  = OFF_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_write,
  input  logic [LA_W:0]     cmd_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_wdata,
  output logic              mem_bank,
  output logic [LA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re
);
  burst_mode_e       cmd_mode_e;
  burst_mode_e       mode_q, mode_d;
  logic              active_q, active_d;
  logic              wr_q, wr_d;
  logic              bank_q, bank_d;
  logic [LA_W-1:0]   ptr_q, ptr_d;
  logic [LA_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              re_q, re_d;
  logic              st_en;
  burst_mode_e       adv_mode;
  logic [LA_W-1:0]   adv_in, adv_out;

  assign cmd_mode_e = burst_mode_e'(cmd_mode);
  assign adv_mode   = cmd_valid ? cmd_mode_e : mode_q;
  assign adv_in     = cmd_valid ? cmd_addr[LA_W-1:0] : ptr_q;

  sram_seq_adv #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_adv (
    .mode   (adv_mode),
    .addr_i (adv_in),
    .addr_o (adv_out)
  );

  // State registers move only when something can change them.
  assign st_en = sel_n | cmd_valid | byte_stb;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    wr_d     = wr_q;
    bank_d   = bank_q;
    ptr_d    = ptr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    we_d     = 1'b0;
    re_d     = 1'b0;
    if (sel_n) begin
      active_d = 1'b0;
    end else if (cmd_valid) begin
      if (cmd_mode_e == MODE_RSVD) begin
        active_d = 1'b0;
      end else begin
        active_d = 1'b1;
        mode_d   = cmd_mode_e;
        wr_d     = cmd_write;
        bank_d   = cmd_addr[LA_W];
        if (cmd_write) begin
          ptr_d = cmd_addr[LA_W-1:0];
        end else begin
          addr_d = cmd_addr[LA_W-1:0];
          re_d   = 1'b1;
          ptr_d  = adv_out;
        end
      end
    end else if (byte_stb && active_q) begin
      if (wr_q) begin
        addr_d  = ptr_q;
        wdata_d = byte_wdata;
        we_d    = 1'b1;
        ptr_d   = adv_out;
        if (mode_q == MODE_BYTE) active_d = 1'b0;
      end else if (mode_q == MODE_BYTE) begin
        active_d = 1'b0;
      end else begin
        addr_d = ptr_q;
        re_d   = 1'b1;
        ptr_d  = adv_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= MODE_BYTE;
      wr_q     <= 1'b0;
      bank_q   <= 1'b0;
      ptr_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (st_en) begin
      active_q <= active_d;
      mode_q   <= mode_d;
      wr_q     <= wr_d;
      bank_q   <= bank_d;
      ptr_q    <= ptr_d;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
    end else begin
      we_q <= we_d;
      re_q <= re_d;
    end
  end

  assign mem_bank  = bank_q;
  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign mem_re    = re_q;

  // R6: the two strobes are exclusive
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9: select high leaves no strobe in the next cycle
  a_r9_select_stop: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !(mem_we || mem_re));

  // R2: a byte-mode write closes its burst
  a_r2_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mode_q == MODE_BYTE) |-> !active_q);

  // R5: bank held while a burst runs without a new command
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cmd_valid) |=> $stable(mem_bank));
endmodule

// File: rtl/sram_seq_rdret.sv
// Read return path: one-cycle valid with a bank-steered data mux.
module sram_seq_rdret #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_re,
  input  logic              mem_bank,
  input  logic [DATA_W-1:0] ping_rdata,
  input  logic [DATA_W-1:0] pong_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic vld_q;
  logic bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= mem_re;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
    end else if (mem_re) begin
      bank_q <= mem_bank;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = bank_q ? pong_rdata : ping_rdata;

  // R8: every read strobe is answered in the next cycle
  a_r8_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> rd_valid);
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 8,
  localparam int LA_W  = OFF_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_write,
  input  logic [LA_W:0]     cmd_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_wdata,
  input  logic [DATA_W-1:0] ping_rdata,
  input  logic [DATA_W-1:0] pong_rdata,
  output logic              mem_bank,
  output logic [LA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s = rst_sync_q[1];

  sram_seq_ctrl #(.OFF_W(OFF_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .sel_n      (sel_n),
    .cmd_valid  (cmd_valid),
    .cmd_mode   (cmd_mode),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .byte_stb   (byte_stb),
    .byte_wdata (byte_wdata),
    .mem_bank   (mem_bank),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re)
  );

  sram_seq_rdret #(.DATA_W(DATA_W)) u_rdret (
    .clk        (clk),
    .rst_n      (rst_s),
    .mem_re     (mem_re),
    .mem_bank   (mem_bank),
    .ping_rdata (ping_rdata),
    .pong_rdata (pong_rdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );
endmodule

// File: tb/sram_burst_seq_test.sv
`timescale 1ns/1ps
module sram_burst_seq_test;
  logic        clk;
  logic        rst_n;
  logic        sel_n;
  logic        cmd_valid;
  logic [1:0]  cmd_mode;
  logic        cmd_write;
  logic [19:0] cmd_addr;
  logic        byte_stb;
  logic [7:0]  byte_wdata;
  logic [7:0]  ping_rdata;
  logic [7:0]  pong_rdata;
  logic        mem_bank;
  logic [18:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_re;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int n_cmp;
  int n_bad;
  bit done;

  logic [19:0] w_ba [256];
  logic [7:0]  w_dt [256];
  int          n_w;
  logic [19:0] r_ba [256];
  int          n_r;
  logic [7:0]  d_log [256];
  int          n_d;

  sram_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_valid(cmd_valid),
    .cmd_mode(cmd_mode), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .byte_stb(byte_stb), .byte_wdata(byte_wdata),
    .ping_rdata(ping_rdata), .pong_rdata(pong_rdata),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic bank, input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {bank, a[18:16], 4'h3};
  endfunction

  // Synchronous SRAM model for both banks
  always @(posedge clk) begin
    if (mem_re) begin
      ping_rdata <= pat(1'b0, mem_addr);
      pong_rdata <= pat(1'b1, mem_addr);
    end
  end

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && n_w < 256) begin
        w_ba[n_w] = {mem_bank, mem_addr};
        w_dt[n_w] = mem_wdata;
        n_w = n_w + 1;
      end
      if (mem_re && n_r < 256) begin
        r_ba[n_r] = {mem_bank, mem_addr};
        n_r = n_r + 1;
      end
      if (rd_valid && n_d < 256) begin
        d_log[n_d] = rd_data;
        n_d = n_d + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] m, input logic w, input logic [19:0] a);
    @(negedge clk);
    sel_n = 1'b0; cmd_valid = 1'b1; cmd_mode = m; cmd_write = w; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    byte_stb = 1'b1; byte_wdata = d;
    @(negedge clk);
    byte_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_sel();
    @(negedge clk);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 we in reset", {31'd0, mem_we}, 32'd0);
    chk("R10 re in reset", {31'd0, mem_re}, 32'd0);
    chk("R10 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_byte_write();
    int b = n_w;
    cmd(2'd0, 1'b1, 20'h12345);
    push(8'h5C); push(8'h11); push(8'h22);
    release_sel();
    chk("R2 byte write count", n_w - b, 1);
    chk("R1 byte write addr", {12'd0, w_ba[b]}, {12'd0, 20'h12345});
    chk("R6 byte write data", {24'd0, w_dt[b]}, 32'h5C);
  endtask

  task automatic t_page_write();
    int b = n_w;
    logic [19:0] base = (20'd1 << 19) | (20'd5 << 9);
    cmd(2'd1, 1'b1, base | 20'd510);
    for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
    release_sel();
    chk("R3 page write count", n_w - b, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 page wrap addr", {12'd0, w_ba[b+i]}, {12'd0, base | 20'((510 + i) % 512)});
      chk("R6 page write data", {24'd0, w_dt[b+i]}, {24'd0, 8'hA0 + 8'(i)});
    end
  endtask

  task automatic t_seq_write();
    int b = n_w;
    logic [19:0] st = (20'd3 << 9) | 20'd511;
    cmd(2'd2, 1'b1, st);
    push(8'h01); push(8'h02);
    release_sel();
    chk("R4 seq page cross count", n_w - b, 2);
    chk("R4 seq first addr", {12'd0, w_ba[b]}, {12'd0, st});
    chk("R4 seq next page addr", {12'd0, w_ba[b+1]}, {12'd0, 20'd4 << 9});
    b = n_w;
    cmd(2'd2, 1'b1, 20'hFFFFE);
    for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
    release_sel();
    chk("R4 seq top count", n_w - b, 4);
    chk("R4 seq addr 0", {12'd0, w_ba[b]},   {12'd0, 20'hFFFFE});
    chk("R4 seq addr 1", {12'd0, w_ba[b+1]}, {12'd0, 20'hFFFFF});
    chk("R5 seq wrap stays pong", {12'd0, w_ba[b+2]}, {12'd0, 20'h80000});
    chk("R5 seq wrap stays pong", {12'd0, w_ba[b+3]}, {12'd0, 20'h80001});
  endtask

  task automatic t_page_read();
    int b = n_r;
    int d = n_d;
    logic [19:0] base = 20'd7 << 9;
    logic [19:0] exp_a [3];
    exp_a[0] = base | 20'd511; exp_a[1] = base; exp_a[2] = base | 20'd1;
    cmd(2'd1, 1'b0, base | 20'd511);
    push(8'h00); push(8'h00);
    release_sel();
    chk("R7 page read count", n_r - b, 3);
    chk("R8 page read data count", n_d - d, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R7 page read addr", {12'd0, r_ba[b+i]}, {12'd0, exp_a[i]});
      chk("R8 ping data", {24'd0, d_log[d+i]}, {24'd0, pat(1'b0, exp_a[i][18:0])});
    end
  endtask

  task automatic t_pong_read();
    int b = n_r;
    int d = n_d;
    cmd(2'd2, 1'b0, 20'hFFFFF);
    push(8'h00);
    release_sel();
    chk("R7 pong read count", n_r - b, 2);
    chk("R4 pong read wrap", {12'd0, r_ba[b+1]}, {12'd0, 20'h80000});
    chk("R8 pong data 0", {24'd0, d_log[d]},   {24'd0, pat(1'b1, 19'h7FFFF)});
    chk("R8 pong data 1", {24'd0, d_log[d+1]}, {24'd0, pat(1'b1, 19'h00000)});
  endtask

  task automatic t_byte_read();
    int b = n_r;
    cmd(2'd0, 1'b0, 20'h00123);
    push(8'h00); push(8'h00);
    release_sel();
    chk("R2 byte read count", n_r - b, 1);
    chk("R7 byte read addr", {12'd0, r_ba[b]}, {12'd0, 20'h00123});
  endtask

  task automatic t_select_drop();
    int b = n_w;
    cmd(2'd1, 1'b1, 20'h00200);
    push(8'h71); push(8'h72);
    @(negedge clk);
    sel_n = 1'b1; byte_stb = 1'b1; byte_wdata = 8'h73;
    @(negedge clk);
    byte_stb = 1'b0;
    repeat (2) @(negedge clk);
    sel_n = 1'b0;
    push(8'h74);
    @(negedge clk);
    sel_n = 1'b1; cmd_valid = 1'b1; cmd_mode = 2'd1; cmd_write = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; sel_n = 1'b0;
    push(8'h75);
    release_sel();
    chk("R9 writes before drop only", n_w - b, 2);
    chk("R9 last write addr", {12'd0, w_ba[b+1]}, {12'd0, 20'h00201});
  endtask

  task automatic t_reserved();
    int bw = n_w;
    int br = n_r;
    cmd(2'd3, 1'b1, 20'h00100);
    push(8'h99);
    cmd(2'd3, 1'b0, 20'h00100);
    push(8'h00);
    release_sel();
    chk("R11 reserved no writes", n_w - bw, 0);
    chk("R11 reserved no reads", n_r - br, 0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    n_w = 0; n_r = 0; n_d = 0;
    rst_n = 1'b0; sel_n = 1'b1; cmd_valid = 1'b0; cmd_mode = 2'd0;
    cmd_write = 1'b0; cmd_addr = '0; byte_stb = 1'b0; byte_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_byte_write();
    t_page_write();
    t_seq_write();
    t_page_read();
    t_pong_read();
    t_byte_read();
    t_select_drop();
    t_reserved();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule